// File: doc/BRIEF.md
# Continuous-Conversion Result Reader for a Sigma-Delta Converter

This block is the host side of a serial link to a sigma-delta converter that converts without pause. After reset it pulls chip select low and keeps it low. It then watches the converter's combined data-out/ready line. A high-to-low transition on that line, seen while the reader is idle, means that a conversion has finished. The reader answers by sending the one-byte read-data command. It then clocks in the 24-bit result and, when asked to, the converter's status byte that follows the result.

Each finished read produces a one-cycle result strobe. The strobe carries the word, the status byte and the channel number taken from that byte. It also carries a late flag, which warns that the read ran past the converter's conversion period, so the next result was probably overwritten. The serial clock runs at a parameterised fraction of the system clock and uses SPI mode 3.

Top module: `adc_stream_reader`

## Requirements
- R1: During reset cs_n_o is high. From the first cycle after reset it stays low. While idle, sclk_o and mosi_o rest high and result_valid_o is low.
- R2: Every read begins with 8 serial clocks. Over these clocks the byte 0x58 goes out on mosi_o MSB first. mosi_o changes only on a falling sclk_o edge, so it is stable while sclk_o is high.
- R3: A read starts only on a high-to-low transition of sdo_i seen while idle. A line that stays high causes no sclk_o activity.
- R4: After the command, the 24-bit result is sampled on rising sclk_o edges, MSB first. It appears unchanged on result_data_o.
- R5: With the status option on, the reader clocks 8 more bits after the result, for 40 rising edges in total. result_status_o carries those 8 bits. result_chan_o equals status bits [CHAN_W-1:0].
- R6: With the status option off, a read uses exactly 32 rising edges, and result_status_o and result_chan_o are zero.
- R7: append_status_i is captured when a read starts. Changing it during the read has no effect on that read's length or on its outputs.
- R8: Each read raises result_valid_o for exactly one cycle.
- R9: result_overrun_o is set with the strobe when CONV_CYCLES or more clock cycles pass from ready detection to the last sample. With the defaults (SCLK_HALF=2, CONV_CYCLES=150), a 32-clock read is not late and a 40-clock read is.
- R10: sclk_o has a period of 2*SCLK_HALF clock cycles while a read runs, and it idles high between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| append_status_i | input | 1 | Request the status byte after each result |
| sdo_i | input | 1 | Converter data-out / conversion-ready line |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial command data to converter |
| result_valid_o | output | 1 | One-cycle strobe for a finished read |
| result_data_o | output | 24 | Conversion result |
| result_status_o | output | 8 | Status byte, zero when not requested |
| result_chan_o | output | CHAN_W | Channel number from the status byte |
| result_overrun_o | output | 1 | Read ran past one conversion period |

## Verification
The serial line does two jobs, and they can collide. The trailing data bits of one read can look like the ready edge for the next, so the last sample and a false high-to-low transition can reach the idle detector at the same time. The bench provokes this case with results whose final bits go from one to zero and with reads issued right after the previous strobe. It judges the outcome by counting serial clocks and strobes: a false start would add clocks and strobes that have no matching conversion. Two other events can also coincide: the end of a read and the expiry of the conversion-period window. The bench tests them by running both frame lengths against the same window and comparing the late flag with a bench-computed read length.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam logic [7:0] RD_DATA_CMD = 8'h58;
  localparam int CMD_BITS  = 8;
  localparam int WORD_BITS = 24;
  localparam int STAT_BITS = 8;
  localparam int RX_BITS   = WORD_BITS + STAT_BITS;
  localparam int FRAME_MAX = CMD_BITS + WORD_BITS + STAT_BITS;
  localparam int FRAME_MIN = CMD_BITS + WORD_BITS;
  localparam int HOLDOFF   = 3;
endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int SCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_tk_o,
  output logic rise_tk_o
);
  localparam int CNT_W = $clog2(SCLK_HALF) + 1;

  logic [CNT_W-1:0] cnt;
  logic             phase;
  logic             wrap;

  assign wrap      = run_i && (cnt == CNT_W'(SCLK_HALF - 1));
  assign fall_tk_o = wrap && !phase;
  assign rise_tk_o = wrap && phase;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt    <= '0;
      phase  <= 1'b0;
      sclk_o <= 1'b1;
    end else if (wrap) begin
      cnt    <= '0;
      phase  <= ~phase;
      sclk_o <= phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter
  import adc_rd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               with_stat_i,
  input  logic               fall_tk_i,
  input  logic               rise_tk_i,
  input  logic               sdo_i,
  output logic               mosi_o,
  output logic               last_o,
  output logic [RX_BITS-1:0] rx_o
);
  localparam int BC_W = $clog2(FRAME_MAX + 1);

  logic [BC_W-1:0]    bit_cnt;
  logic [BC_W-1:0]    frame_len;
  logic [7:0]         tx_sh;
  logic [RX_BITS-1:0] rx_sh;

  assign frame_len = with_stat_i ? BC_W'(FRAME_MAX) : BC_W'(FRAME_MIN);
  assign last_o    = rise_tk_i && (bit_cnt == frame_len - 1'b1);
  assign rx_o      = {rx_sh[RX_BITS-2:0], sdo_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      tx_sh   <= '1;
      rx_sh   <= '0;
      mosi_o  <= 1'b1;
    end else if (start_i) begin
      bit_cnt <= '0;
      tx_sh   <= RD_DATA_CMD;
      mosi_o  <= 1'b1;
    end else begin
      if (fall_tk_i) begin
        mosi_o <= tx_sh[7];
        tx_sh  <= {tx_sh[6:0], 1'b1};
      end
      if (rise_tk_i) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt >= BC_W'(CMD_BITS)) rx_sh <= {rx_sh[RX_BITS-2:0], sdo_i};
      end
    end
  end
endmodule

// File: rtl/adc_rd_overlap.sv
module adc_rd_overlap #(
  parameter int CONV_CYCLES = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic busy_i,
  output logic late_o
);
  localparam int EL_W = $clog2(CONV_CYCLES + 1);

  logic [EL_W-1:0] elapsed;

  assign late_o = (elapsed >= EL_W'(CONV_CYCLES));

  always_ff @(posedge clk) begin
    if (rst || start_i) elapsed <= '0;
    else if (busy_i && !late_o) elapsed <= elapsed + 1'b1;
  end
endmodule

// File: rtl/adc_stream_reader.sv
module adc_stream_reader
  import adc_rd_pkg::*;
#(
  parameter int SCLK_HALF   = 2,
  parameter int CONV_CYCLES = 150,
  parameter int CHAN_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 append_status_i,
  input  logic                 sdo_i,
  output logic                 cs_n_o,
  output logic                 sclk_o,
  output logic                 mosi_o,
  output logic                 result_valid_o,
  output logic [WORD_BITS-1:0] result_data_o,
  output logic [STAT_BITS-1:0] result_status_o,
  output logic [CHAN_W-1:0]    result_chan_o,
  output logic                 result_overrun_o
);
  localparam int HO_W = $clog2(HOLDOFF + 1);

  logic               s1, s2, s3;
  logic               busy, stat_q;
  logic [HO_W-1:0]    holdoff;
  logic               start, last, late;
  logic               fall_tk, rise_tk;
  logic [RX_BITS-1:0] rx;

  // Line synchroniser; s3 holds the previous synchronised level.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= sdo_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  // A ready edge counts only once stale data bits have left the synchroniser.
  assign start = !busy && (holdoff == '0) && s3 && !s2;

  adc_rd_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_sclk (
    .clk(clk), .rst(rst), .run_i(busy),
    .sclk_o(sclk_o), .fall_tk_o(fall_tk), .rise_tk_o(rise_tk)
  );

  adc_rd_shifter u_shift (
    .clk(clk), .rst(rst), .start_i(start), .with_stat_i(stat_q),
    .fall_tk_i(fall_tk), .rise_tk_i(rise_tk), .sdo_i(sdo_i),
    .mosi_o(mosi_o), .last_o(last), .rx_o(rx)
  );

  adc_rd_overlap #(.CONV_CYCLES(CONV_CYCLES)) u_ovl (
    .clk(clk), .rst(rst), .start_i(start), .busy_i(busy), .late_o(late)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_o           <= 1'b1;
      busy             <= 1'b0;
      stat_q           <= 1'b0;
      holdoff          <= '0;
      result_valid_o   <= 1'b0;
      result_data_o    <= '0;
      result_status_o  <= '0;
      result_chan_o    <= '0;
      result_overrun_o <= 1'b0;
    end else begin
      cs_n_o         <= 1'b0;
      result_valid_o <= 1'b0;
      if (holdoff != '0) holdoff <= holdoff - 1'b1;
      if (start) begin
        busy   <= 1'b1;
        stat_q <= append_status_i;
      end
      if (last) begin
        busy             <= 1'b0;
        holdoff          <= HO_W'(HOLDOFF);
        result_valid_o   <= 1'b1;
        result_overrun_o <= late;
        if (stat_q) begin
          result_data_o   <= rx[RX_BITS-1:STAT_BITS];
          result_status_o <= rx[STAT_BITS-1:0];
          result_chan_o   <= rx[CHAN_W-1:0];
        end else begin
          result_data_o   <= rx[WORD_BITS-1:0];
          result_status_o <= '0;
          result_chan_o   <= '0;
        end
      end
    end
  end

  // R1
  cs_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !cs_n_o);

  // R2
  mosi_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |=> !result_valid_o);

  // R10
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk_o);

  // R6
  nostat_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (result_valid_o && result_status_o == '0) |-> (result_chan_o == '0));
endmodule

// File: tb/adc_stream_reader_tb.sv
module adc_stream_reader_tb;
  localparam int SCLK_HALF   = 2;
  localparam int CONV_CYCLES = 150;
  localparam int CHAN_W      = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic append = 1'b0;
  logic sdo_r = 1'b1;
  logic cs_n, sclk, mosi, valid, ovr;
  logic [23:0] data;
  logic [7:0]  status;
  logic [CHAN_W-1:0] chan;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  adc_stream_reader #(.SCLK_HALF(SCLK_HALF), .CONV_CYCLES(CONV_CYCLES), .CHAN_W(CHAN_W)) u_dut (
    .clk(clk), .rst(rst), .append_status_i(append), .sdo_i(sdo_r),
    .cs_n_o(cs_n), .sclk_o(sclk), .mosi_o(mosi), .result_valid_o(valid),
    .result_data_o(data), .result_status_o(status), .result_chan_o(chan),
    .result_overrun_o(ovr)
  );

  // Converter model
  logic [31:0] dev_frame = '0;
  int          dev_total = 32;
  int          conv_id = 0;
  int          seen_id = 0;
  int          rc = 0;
  logic [7:0]  cmd_seen = '0;
  logic        last_sclk = 1'b1;
  int          sclk_falls = 0;

  always @(sclk or conv_id) begin
    if (conv_id != seen_id) begin
      seen_id  = conv_id;
      rc       = 0;
      cmd_seen = '0;
      sdo_r    = 1'b0;
    end else if (sclk && !last_sclk) begin
      if (rc < 8) cmd_seen = {cmd_seen[6:0], mosi};
      rc = rc + 1;
      if (rc == dev_total) sdo_r = 1'b1;
    end else if (!sclk && last_sclk) begin
      sclk_falls = sclk_falls + 1;
      if (rc >= 8 && rc < dev_total) sdo_r = dev_frame[31 - (rc - 8)];
      else sdo_r = 1'b1;
    end
    last_sclk = sclk;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_late(input int frame_bits);
    return (frame_bits * 2 * SCLK_HALF) >= CONV_CYCLES;
  endfunction

  function automatic logic [CHAN_W-1:0] exp_chan(input logic [7:0] st, input bit en);
    return en ? st[CHAN_W-1:0] : '0;
  endfunction

  task automatic do_read(input logic [23:0] w, input logic [7:0] st, input bit en, input bit flip);
    int  t;
    int  hi;
    bit  got;
    int  total;
    total = en ? 40 : 32;
    @(negedge clk);
    append    = en;
    dev_frame = {w, st};
    dev_total = total;
    conv_id   = conv_id + 1;
    got = 0;
    t   = 0;
    hi  = 0;
    while (!got && t < 3000) begin
      @(negedge clk);
      t++;
      if (flip && t == 40) append = ~append;
      if (!sclk && (t % (2 * SCLK_HALF)) == 0) hi++;
      if (valid) got = 1;
    end
    check(got, "R8 strobe seen", 64'(got), 64'd1);
    if (got) begin
      check(data == w, "R4 data", 64'(data), 64'(w));
      check(status == (en ? st : 8'h00), en ? "R5 status" : "R6 status zero", 64'(status), 64'(en ? st : 8'h00));
      check(chan == exp_chan(st, en), en ? "R5 chan" : "R6 chan zero", 64'(chan), 64'(exp_chan(st, en)));
      check(ovr == exp_late(total), "R9 late flag", 64'(ovr), 64'(exp_late(total)));
      check(cmd_seen == 8'h58, "R2 command byte", 64'(cmd_seen), 64'h58);
      check(rc == total, flip ? "R7 frame length latched" : "R10 clock count", 64'(rc), 64'(total));
      check(sclk == 1'b1, "R10 sclk idle high", 64'(sclk), 64'd1);
      @(negedge clk);
      check(valid == 1'b0, "R8 single cycle", 64'(valid), 64'd0);
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int f0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R1 cs high in reset", 64'(cs_n), 64'd1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(cs_n == 1'b0, "R1 cs low", 64'(cs_n), 64'd0);
    check(sclk == 1'b1, "R1 sclk idle", 64'(sclk), 64'd1);
    check(mosi == 1'b1, "R1 mosi idle", 64'(mosi), 64'd1);
    check(valid == 1'b0, "R1 no strobe", 64'(valid), 64'd0);

    // R3: a quiet high line must not start a read
    f0 = sclk_falls;
    repeat (300) @(negedge clk);
    check(sclk_falls == f0, "R3 no clocks while line high", 64'(sclk_falls), 64'(f0));

    // directed corners
    do_read(24'h000000, 8'hFF, 1'b1, 1'b0);
    do_read(24'hFFFFFF, 8'h00, 1'b1, 1'b0);
    do_read(24'h800001, 8'h00, 1'b0, 1'b0);
    do_read(24'hFFFFFE, 8'hA5, 1'b0, 1'b0);
    do_read(24'h5A5A5A, 8'h3C, 1'b1, 1'b1); // R7 flip mid-read
    do_read(24'h123456, 8'h07, 1'b0, 1'b1); // R7 flip mid-read

    for (int i = 0; i < 24; i++) begin
      do_read(24'($urandom), 8'($urandom), 1'($urandom), 1'b0);
    end

    f0 = sclk_falls;
    repeat (200) @(negedge clk);
    check(sclk_falls == f0, "R3 no spurious read after last frame", 64'(sclk_falls), 64'(f0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule